// File: doc/BRIEF.md
# Stack Top Exchange Sequencer

This block swaps a multibyte CPU register with the bytes at the top of the stack. It uses a byte-wide memory port whose read data comes back one cycle after the read strobe. A one-cycle start pulse carries four things: the register value, both stack pointers, the address-mode bit, and two override flags. The override flags come from an already decoded size prefix. The sequencer then reads each stack byte and, in the very next cycle, writes the matching register byte to the same address. It returns the swapped register value with a done pulse.

There are two forms of the exchange. The wide form moves three bytes through the 24-bit pointer. The narrow form moves two bytes through the 16-bit pointer, and its addresses are zero-extended. The mode bit picks the form unless an override flag applies. The total latency is fixed by the instruction variant: a base of 5 cycles for the narrow form or 7 for the wide form, plus one cycle if an override applied, plus one cycle for an index register. Idle cycles after the memory traffic fill out that count. Stack pointers are inputs only and are never changed, and no flags are produced.

Top module: `stk_xchg_seq`

## Requirements
- R1: In the wide form, three bytes are exchanged: register bits 7:0 go to SP, bits 15:8 to SP+1, and bits 23:16 to SP+2. The byte read from SP+k becomes byte k of reg_o.
- R2: In the narrow form, only SP and SP+1 are exchanged. reg_o[23:16] keeps the value of reg_i[23:16], and SP+2 is not written.
- R3: The form is selected as follows. With wide_mode_i=1, the wide form is used unless force_short_i=1. With wide_mode_i=0, the narrow form is used unless force_long_i=1. force_long_i is ignored in wide mode, and force_short_i is ignored in narrow mode.
- R4: The wide form addresses from the 24-bit pointer sp_long_i. The narrow form addresses from sp_short_i, with address bits 23:16 at zero and SP+k wrapping inside 16 bits (0xFFFF+1 = 0x0000).
- R5: done_o pulses for one cycle, exactly N cycles after the clock edge that accepts start_i. N = 5 (narrow) or 7 (wide), plus 1 if an override flag applied, plus 1 if index_reg_i=1.
- R6: busy_o is high from the cycle after acceptance through the done cycle and low in the cycle after done. A start_i pulse while busy_o is high has no effect.
- R7: Each byte takes one read cycle followed at once by one write cycle to the same address. mem_rd_o and mem_wr_o are never high together, and bytes are handled in order k = 0, 1, 2.
- R8: reg_o holds the exchanged value from the done cycle until the next start is accepted.
- R9: While reset is held and while idle, busy_o, done_o, mem_rd_o and mem_wr_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| wide_mode_i | input | 1 | Address mode: 1 = 24-bit, 0 = 16-bit |
| force_short_i | input | 1 | Narrow-form override (used in wide mode only) |
| force_long_i | input | 1 | Wide-form override (used in narrow mode only) |
| index_reg_i | input | 1 | Register is an index register (adds one cycle) |
| reg_i | input | 24 | Register value to exchange |
| sp_long_i | input | 24 | 24-bit stack pointer |
| sp_short_i | input | 16 | 16-bit stack pointer |
| mem_addr_o | output | 24 | Memory byte address |
| mem_rd_o | output | 1 | Read strobe; data returns next cycle |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after mem_rd_o |
| reg_o | output | 24 | Exchanged register value |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Final cycle of the sequence |

## Verification
The result of a start accepted at edge E is due in the Nth cycle after E, where N comes from the R5 formula. The bench counts busy cycles on falling edges, so done_o must arrive exactly when that count reaches the N the driver computed. At that same sample the monitor checks reg_o and reads back the memory model, because the last write landed at the edge ending cycle 2·bytes, which is always before cycle N. The fall of busy_o is checked one sample later, and the hold of reg_o a few samples after that.

// File: rtl/stk_xchg_pkg.sv
package stk_xchg_pkg;
  localparam int BYTE_W     = 8;
  localparam int NB_WIDE    = 3;
  localparam int NB_NARROW  = 2;
  localparam int BASE_NARROW = 5;
  localparam int BASE_WIDE   = 7;
  localparam int REG_W      = NB_WIDE * BYTE_W;
  localparam int SPS_W      = NB_NARROW * BYTE_W;
  localparam int CNT_W      = $clog2(BASE_WIDE + 3);
  localparam int K_W        = $clog2(NB_WIDE);

  function automatic logic pick_wide(logic mode, logic fs, logic fl);
    return mode ? !fs : fl;
  endfunction

  function automatic logic pick_ovr(logic mode, logic fs, logic fl);
    return mode ? fs : fl;
  endfunction
endpackage

// File: rtl/stk_xchg_ctl.sv
module stk_xchg_ctl
  import stk_xchg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q, len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(1);
        len_q  <= len_i;
      end
    end else if (cnt_q == len_q) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == len_q);
  assign cnt_o  = cnt_q;

  p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_ends_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  p_busy_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/stk_xchg_agen.sv
module stk_xchg_agen
  import stk_xchg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             wide_i,
  input  logic [REG_W-1:0] sp_long_i,
  input  logic [SPS_W-1:0] sp_short_i,
  input  logic [K_W-1:0]   k_i,
  output logic             wide_o,
  output logic [REG_W-1:0] addr_o
);
  logic             wide_q;
  logic [REG_W-1:0] base_q;
  logic [SPS_W-1:0] short_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wide_q <= 1'b0;
      base_q <= '0;
    end else if (accept_i) begin
      wide_q <= wide_i;
      base_q <= wide_i ? sp_long_i : {{(REG_W-SPS_W){1'b0}}, sp_short_i};
    end
  end

  // narrow form wraps inside the 16-bit space
  assign short_addr = base_q[SPS_W-1:0] + SPS_W'(k_i);
  assign addr_o = wide_q ? base_q + REG_W'(k_i)
                         : {{(REG_W-SPS_W){1'b0}}, short_addr};
  assign wide_o = wide_q;
endmodule

// File: rtl/stk_xchg_data.sv
module stk_xchg_data
  import stk_xchg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic              wr_i,
  input  logic [K_W-1:0]    k_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic [BYTE_W-1:0] wdata_o,
  output logic [REG_W-1:0]  src_o,
  output logic [REG_W-1:0]  res_o
);
  logic [REG_W-1:0] src_q, res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else if (accept_i) src_q <= reg_i;
  end

  for (genvar g = 0; g < NB_WIDE; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) res_q[g*BYTE_W +: BYTE_W] <= '0;
      else if (accept_i) res_q[g*BYTE_W +: BYTE_W] <= reg_i[g*BYTE_W +: BYTE_W];
      else if (wr_i && (k_i == K_W'(g))) res_q[g*BYTE_W +: BYTE_W] <= rdata_i;
    end
  end

  assign wdata_o = src_q[k_i*BYTE_W +: BYTE_W];
  assign src_o   = src_q;
  assign res_o   = res_q;
endmodule

// File: rtl/stk_xchg_seq.sv
module stk_xchg_seq
  import stk_xchg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wide_mode_i,
  input  logic              force_short_i,
  input  logic              force_long_i,
  input  logic              index_reg_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [REG_W-1:0]  sp_long_i,
  input  logic [SPS_W-1:0]  sp_short_i,
  output logic [REG_W-1:0]  mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [REG_W-1:0]  reg_o,
  output logic              busy_o,
  output logic              done_o
);
  logic             wide_sel, ovr_sel, accept, wide_q, xfer;
  logic [CNT_W-1:0] len, cnt, nb2;
  logic [K_W-1:0]   k;
  logic [REG_W-1:0] src;

  assign wide_sel = pick_wide(wide_mode_i, force_short_i, force_long_i);
  assign ovr_sel  = pick_ovr(wide_mode_i, force_short_i, force_long_i);
  assign len = (wide_sel ? CNT_W'(BASE_WIDE) : CNT_W'(BASE_NARROW))
             + CNT_W'(ovr_sel) + CNT_W'(index_reg_i);
  assign accept = start_i && !busy_o;

  stk_xchg_ctl u_ctl (
    .clk_i, .rst_ni, .start_i, .len_i(len),
    .busy_o, .done_o, .cnt_o(cnt)
  );

  stk_xchg_agen u_agen (
    .clk_i, .rst_ni, .accept_i(accept), .wide_i(wide_sel),
    .sp_long_i, .sp_short_i, .k_i(k), .wide_o(wide_q), .addr_o(mem_addr_o)
  );

  // odd count = read of byte k, following even count = write of byte k
  assign nb2  = wide_q ? CNT_W'(2*NB_WIDE) : CNT_W'(2*NB_NARROW);
  assign xfer = busy_o && (cnt <= nb2);
  assign k    = K_W'((cnt - 1'b1) >> 1);
  assign mem_rd_o = xfer &&  cnt[0];
  assign mem_wr_o = xfer && !cnt[0];

  stk_xchg_data u_data (
    .clk_i, .rst_ni, .accept_i(accept), .reg_i,
    .wr_i(mem_wr_o), .k_i(k), .rdata_i(mem_rdata_i),
    .wdata_o(mem_wdata_o), .src_o(src), .res_o(reg_o)
  );

  p_rw_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  p_wr_after_rd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> $past(mem_rd_o) && (mem_addr_o == $past(mem_addr_o)));
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_rd_o && !mem_wr_o && !done_o);
  p_upper_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !wide_q) |-> reg_o[REG_W-1 -: BYTE_W] == src[REG_W-1 -: BYTE_W]);
  p_narrow_high_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !wide_q) |-> mem_addr_o[REG_W-1:SPS_W] == '0);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(reg_o));
endmodule

// File: tb/sim_stk_xchg_seq.sv
module sim_stk_xchg_seq;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, wmode = 0, fsh = 0, flg = 0, idx = 0;
  logic [23:0] reg_in = '0, spl = '0;
  logic [15:0] sps = '0;
  logic [23:0] addr, reg_out;
  logic rd, wr, busy, done;
  logic [7:0] wdata, rdata = '0;

  int errors = 0, checks = 0;
  logic [7:0] mem [int];

  typedef struct {
    int len; int nb; logic [23:0] res; logic [23:0] src; bit wide; int base; string tag;
  } item_t;
  item_t q[$];

  always #(PERIOD/2) clk = ~clk;

  stk_xchg_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wide_mode_i(wmode),
    .force_short_i(fsh), .force_long_i(flg), .index_reg_i(idx), .reg_i(reg_in),
    .sp_long_i(spl), .sp_short_i(sps), .mem_addr_o(addr), .mem_rd_o(rd),
    .mem_wr_o(wr), .mem_wdata_o(wdata), .mem_rdata_i(rdata), .reg_o(reg_out),
    .busy_o(busy), .done_o(done)
  );

  function automatic logic [7:0] rmem(int a);
    return mem.exists(a) ? mem[a] : 8'(a ^ 32'hA5);
  endfunction

  function automatic int badr(bit w, int base, int k);
    return w ? ((base + k) & 32'hFFFFFF) : ((base + k) & 32'hFFFF);
  endfunction

  always @(posedge clk) begin
    if (rd) rdata <= rmem(int'(addr));
    if (wr) mem[int'(addr)] = wdata;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: counts busy cycles and accesses, compares at done
  int cyc = 0, nrd = 0, nwr = 0;
  bit chk_drop = 0;
  logic [23:0] last_res = '0;
  always @(negedge clk) begin
    if (chk_drop) begin
      check(!busy, "R6", "busy after done", int'(busy), 0);
      chk_drop = 0;
    end
    if (busy) begin
      cyc++;
      if (rd) nrd++;
      if (wr) nwr++;
      if (done) begin
        item_t it;
        if (q.size() == 0) check(0, "R5", "done without item", 1, 0);
        else begin
          it = q.pop_front();
          check(cyc == it.len, "R5", {it.tag, " latency"}, cyc, it.len);
          check(reg_out == it.res, it.wide ? "R1" : "R2", {it.tag, " reg_o"},
                int'(reg_out), int'(it.res));
          check(nwr == it.nb && nrd == it.nb, "R3", {it.tag, " byte count"}, nwr, it.nb);
          for (int k = 0; k < it.nb; k++)
            check(rmem(badr(it.wide, it.base, k)) == it.src[k*8 +: 8], "R4",
                  {it.tag, " stack byte"}, int'(rmem(badr(it.wide, it.base, k))),
                  int'(it.src[k*8 +: 8]));
          last_res = it.res;
          chk_drop = 1;
        end
      end
    end else begin
      cyc = 0; nrd = 0; nwr = 0;
    end
  end

  // driver: computes expectation, pushes it, pulses start
  task automatic run(string tag, bit m, bit s, bit l, bit ix, logic [23:0] r,
                     logic [23:0] pl, logic [15:0] ps, bit glitch);
    item_t it;
    bit w = m ? !s : l;
    bit ov = m ? s : l;
    it.wide = w;
    it.nb = w ? 3 : 2;
    it.len = (w ? 7 : 5) + int'(ov) + int'(ix);
    it.base = w ? int'(pl) : int'(ps);
    it.src = r;
    it.res = r;
    it.tag = tag;
    for (int k = 0; k < it.nb; k++) it.res[k*8 +: 8] = rmem(badr(w, it.base, k));
    q.push_back(it);
    @(negedge clk);
    wmode = m; fsh = s; flg = l; idx = ix; reg_in = r; spl = pl; sps = ps; start = 1;
    @(negedge clk);
    start = 0;
    if (glitch) begin  // R6: start while busy must be ignored
      @(negedge clk);
      reg_in = ~r; spl = pl + 24'h100; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(!busy && !done && !rd && !wr, "R9", "reset outputs", int'({busy, done, rd, wr}), 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !rd && !wr, "R9", "idle outputs", int'({busy, rd, wr}), 0);
    mem[24'h001000] = 8'h11; mem[24'h001001] = 8'h22; mem[24'h001002] = 8'h33;
    // R1/R3 wide mode, HL and index register
    run("wide hl",   1, 0, 0, 0, 24'hABCDEF, 24'h001000, 16'h2000, 0);
    run("wide idx",  1, 0, 0, 1, 24'h123456, 24'h001000, 16'h2000, 0);
    // R2/R3 narrow mode
    run("narrow hl",  0, 0, 0, 0, 24'h778899, 24'h003000, 16'h4000, 0);
    run("narrow idx", 0, 0, 0, 1, 24'hC0FFEE, 24'h003000, 16'h4010, 0);
    check(rmem(24'h4012) == 8'(32'h4012 ^ 32'hA5), "R2", "third byte untouched",
          int'(rmem(24'h4012)), int'(8'(32'h4012 ^ 32'hA5)));
    // R3 overrides, plus ignored flags
    run("wide+short hl",  1, 1, 0, 0, 24'h0A0B0C, 24'h005000, 16'h6000, 0);
    run("narrow+long idx", 0, 0, 1, 1, 24'h0D0E0F, 24'h007000, 16'h8000, 0);
    run("narrow+long hl",  0, 0, 1, 0, 24'h135790, 24'h007100, 16'h8000, 0);
    run("wide+short idx",  1, 1, 0, 1, 24'h2468AC, 24'h005000, 16'h6100, 0);
    run("wide ign long",   1, 0, 1, 0, 24'h445566, 24'h009000, 16'hA000, 0);
    run("narrow ign short", 0, 1, 0, 0, 24'h998877, 24'h009000, 16'hA100, 0);
    // R4 16-bit wrap and long pointer high bits
    run("narrow wrap", 0, 0, 0, 0, 24'hFEDCBA, 24'hFF0000, 16'hFFFF, 0);
    run("wide high",   1, 0, 0, 0, 24'h5A5A5A, 24'hFFFFFE, 16'h0000, 0);
    // R6 start during busy
    run("glitch", 1, 0, 0, 1, 24'h314159, 24'h00A000, 16'h0100, 1);
    // R8 hold after done
    repeat (3) @(negedge clk);
    check(reg_out == last_res && !busy, "R8", "reg_o hold", int'(reg_out), int'(last_res));
    check(q.size() == 0, "R5", "all items retired", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule